// File: doc/BRIEF.md
# Packet-Filter Branch Evaluation Stage

This stage decides conditional jumps for a 64-bit packet-filter virtual-machine core. Each accepted cycle delivers one decoded 64-bit instruction word, the program counter of that instruction and the values already read from its two named registers. One cycle later the stage presents three results: whether the branch is taken, the next program counter, and a flag for an opcode it cannot handle.

Two jump classes are evaluated. One compares full 64-bit values. The other compares only the low 32-bit halves of the operands, and takes the sign for signed conditions from bit 31. The second comparand is either the source register value or the 32-bit immediate carried in the instruction. Program counters count 8-byte instruction slots, so a branch offset is a count of slots. The result register uses a valid/ready handshake, and a result that is not yet consumed blocks new input.

Top module: `pfb_branch_unit`

## Requirements
- R1: The opcode byte is `insn[63:56]`. Its low three bits (`insn[58:56]`) give the class: 5 is a 64-bit compare, 6 is a 32-bit compare. Any other class sets `out_illegal`, clears `out_taken` and gives a next PC of pc+1.
- R2: Opcode bit 3 (`insn[59]`) picks the second comparand. 1 selects `src_val` and 0 selects the immediate `insn[31:0]`.
- R3: The condition nibble `insn[63:60]` has these codes: 0x1 equal, 0x5 not equal, 0x2 unsigned greater, 0x3 unsigned greater-or-equal, 0xa unsigned less, 0xb unsigned less-or-equal, 0x6 signed greater, 0x7 signed greater-or-equal, 0xc signed less, 0xd signed less-or-equal. The destination value is the left operand.
- R4: In class 5 with an immediate comparand, the immediate is sign-extended to 64 bits before the compare.
- R5: In class 6 only bits 31:0 of each operand matter. Signed conditions take the sign from bit 31, and the immediate is used unchanged.
- R6: A taken branch gives a next PC of pc + 1 + offset. The offset is the signed 16-bit field `insn[47:32]`, and the sum wraps modulo 2^PC_W.
- R7: A branch that is not taken gives a next PC of pc + 1, wrapping modulo 2^PC_W.
- R8: The condition codes not listed in R3 (0x0, 0x4, 0x8, 0x9, 0xe, 0xf) set `out_illegal` and clear `out_taken` in either class.
- R9: An input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when no result is held or when `out_ready` is high. `out_valid` rises one cycle after acceptance, and the result stays unchanged until `out_ready` is seen.
- R10: During reset `out_valid`, `out_taken`, `out_illegal` and `out_next_pc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| insn | input | 64 | Decoded instruction word |
| pc | input | PC_W (32) | Slot index of the instruction |
| dst_val | input | 64 | Destination register value (left operand) |
| src_val | input | 64 | Source register value |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch is taken |
| out_next_pc | output | PC_W (32) | Slot index to fetch next |
| out_illegal | output | 1 | Opcode is not handled by this stage |

## Verification
The bound checker checks every cycle that the handshake holds: a result appears one cycle after acceptance and stays frozen while it is stalled. It also checks that an illegal result is never taken, that the next PC equals the fall-through or the offset target of the captured instruction, and that only the two jump classes can yield a legal result. Whether the comparison itself is right cannot be checked cycle by cycle. That needs the bench's vectors: each condition code in both widths, sign-extended against raw immediates, upper words that must be ignored, sign taken from bit 31, and PC wrap and extreme offsets.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int OFF_W  = 16;

  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  localparam logic [3:0] CND_EQ  = 4'h1;
  localparam logic [3:0] CND_UGT = 4'h2;
  localparam logic [3:0] CND_UGE = 4'h3;
  localparam logic [3:0] CND_NE  = 4'h5;
  localparam logic [3:0] CND_SGT = 4'h6;
  localparam logic [3:0] CND_SGE = 4'h7;
  localparam logic [3:0] CND_ULT = 4'ha;
  localparam logic [3:0] CND_ULE = 4'hb;
  localparam logic [3:0] CND_SLT = 4'hc;
  localparam logic [3:0] CND_SLE = 4'hd;

  // Three primitive relations of left against right; every condition derives from them.
  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
  } rel_t;

  function automatic logic cond_known(input logic [3:0] c);
    case (c)
      CND_EQ, CND_NE, CND_UGT, CND_UGE, CND_ULT, CND_ULE,
      CND_SGT, CND_SGE, CND_SLT, CND_SLE: cond_known = 1'b1;
      default:                            cond_known = 1'b0;
    endcase
  endfunction

  function automatic logic cond_apply(input logic [3:0] c, input rel_t r);
    case (c)
      CND_EQ:  cond_apply = r.eq;
      CND_NE:  cond_apply = !r.eq;
      CND_ULT: cond_apply = r.ult;
      CND_ULE: cond_apply = r.ult || r.eq;
      CND_UGT: cond_apply = !(r.ult || r.eq);
      CND_UGE: cond_apply = !r.ult;
      CND_SLT: cond_apply = r.slt;
      CND_SLE: cond_apply = r.slt || r.eq;
      CND_SGT: cond_apply = !(r.slt || r.eq);
      CND_SGE: cond_apply = !r.slt;
      default: cond_apply = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pfb_decode.sv
module pfb_decode
  import pfb_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output logic              is_wide,
  output logic              is_narrow,
  output logic              use_src,
  output logic [3:0]        cond,
  output logic [OFF_W-1:0]  off,
  output logic [HALF_W-1:0] imm,
  output logic              bad_op
);
  logic [2:0] cls;

  always_comb begin
    cls       = insn[58:56];
    use_src   = insn[59];
    cond      = insn[63:60];
    off       = insn[47:32];
    imm       = insn[31:0];
    is_wide   = (cls == CLS_WIDE);
    is_narrow = (cls == CLS_NARROW);
    bad_op    = !(is_wide || is_narrow) || !cond_known(cond);
  end
endmodule

// File: rtl/pfb_relate.sv
module pfb_relate
  import pfb_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output rel_t         rel
);
  always_comb begin
    rel.eq  = (lhs == rhs);
    rel.ult = (lhs < rhs);
    rel.slt = ($signed(lhs) < $signed(rhs));
  end
endmodule

// File: rtl/pfb_target.sv
module pfb_target
  import pfb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             take,
  output logic [PC_W-1:0]  next_pc
);
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] seq_pc;

  generate
    if (PC_W > OFF_W) begin : g_extend
      assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + PC_W'(1);
  assign next_pc = take ? (seq_pc + off_ext) : seq_pc;
endmodule

// File: rtl/pfb_branch_unit.sv
module pfb_branch_unit
  import pfb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       insn,
  input  logic [PC_W-1:0]   pc,
  input  logic [63:0]       dst_val,
  input  logic [63:0]       src_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_illegal
);
  logic              is_wide, is_narrow, use_src, bad_op;
  logic [3:0]        cond;
  logic [OFF_W-1:0]  off;
  logic [HALF_W-1:0] imm;
  logic [WORD_W-1:0] rhs_full;
  rel_t              rel_wide, rel_narrow, rel_sel;
  logic              accept, taken_d;
  logic [PC_W-1:0]   next_d;
  logic              unused_reg_idx;

  // Register index fields are resolved upstream; only the values arrive here.
  assign unused_reg_idx = ^insn[55:48];

  pfb_decode u_decode (
    .insn(insn), .is_wide(is_wide), .is_narrow(is_narrow), .use_src(use_src),
    .cond(cond), .off(off), .imm(imm), .bad_op(bad_op)
  );

  // Immediate is sign-extended for the wide compare; the narrow compare sees only its low word.
  assign rhs_full = use_src ? src_val : {{(WORD_W-HALF_W){imm[HALF_W-1]}}, imm};

  pfb_relate #(.W(WORD_W)) u_rel_wide (
    .lhs(dst_val), .rhs(rhs_full), .rel(rel_wide)
  );

  pfb_relate #(.W(HALF_W)) u_rel_narrow (
    .lhs(dst_val[HALF_W-1:0]), .rhs(rhs_full[HALF_W-1:0]), .rel(rel_narrow)
  );

  assign rel_sel = is_narrow ? rel_narrow : rel_wide;
  assign taken_d = !bad_op && cond_apply(cond, rel_sel);

  pfb_target #(.PC_W(PC_W)) u_target (
    .pc(pc), .off(off), .take(taken_d), .next_pc(next_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_illegal <= 1'b0;
      out_next_pc <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_taken   <= taken_d;
      out_illegal <= bad_op;
      out_next_pc <= next_d;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pfb_branch_unit_chk.sv
module pfb_branch_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic [2:0]      cls_in,
  input logic [15:0]     off_in,
  input logic [PC_W-1:0] pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic            out_illegal,
  input logic [PC_W-1:0] out_next_pc
);
  logic [PC_W-1:0] pc_cap;
  logic [15:0]     off_cap;
  logic [2:0]      cls_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_cap  <= '0;
      off_cap <= '0;
      cls_cap <= '0;
    end else if (accept) begin
      pc_cap  <= pc;
      off_cap <= off_in;
      cls_cap <= cls_in;
    end
  end

  a_r9_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_taken) && $stable(out_illegal) && $stable(out_next_pc)));

  a_r8_illegal_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_taken);

  a_r1_legal_class_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (cls_cap == 3'd5 || cls_cap == 3'd6));

  a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_next_pc == pc_cap + PC_W'(1)));

  a_r6_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken) |->
      (out_next_pc == pc_cap + PC_W'(1) + PC_W'($signed(off_cap))));
endmodule

bind pfb_branch_unit pfb_branch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cls_in(insn[58:56]),
  .off_in(insn[47:32]), .pc(pc), .out_valid(out_valid), .out_ready(out_ready),
  .out_taken(out_taken), .out_illegal(out_illegal), .out_next_pc(out_next_pc)
);

// File: tb/pfb_branch_unit_bench.sv
module pfb_branch_unit_bench;
  localparam int PC_W = 32;
  localparam int NV   = 30;
  // {opcode, offset, imm, dst, src, exp_taken, exp_illegal}
  localparam logic [185:0] VEC [NV] = '{
    {8'h1d, 16'd3,      32'd0,         64'd5,                   64'd5,                 1'b1, 1'b0}, // R3 eq
    {8'h5d, 16'd3,      32'd0,         64'd5,                   64'd5,                 1'b0, 1'b0}, // R3 ne
    {8'h2d, 16'hffff,   32'd0,         64'hffffffffffffffff,    64'd1,                 1'b1, 1'b0}, // R3 ugt
    {8'h6d, 16'd4,      32'd0,         64'hffffffffffffffff,    64'd1,                 1'b0, 1'b0}, // R3 sgt
    {8'hcd, 16'd0,      32'd0,         64'hffffffffffffffff,    64'd1,                 1'b1, 1'b0}, // R3 slt
    {8'had, 16'd9,      32'd0,         64'd1,                   64'hffffffffffffffff,  1'b1, 1'b0}, // R3 ult
    {8'h3d, 16'd2,      32'd0,         64'd7,                   64'd7,                 1'b1, 1'b0}, // R3 uge
    {8'hbd, 16'd2,      32'd0,         64'd2,                   64'd1,                 1'b0, 1'b0}, // R3 ule
    {8'h7d, 16'd5,      32'd0,         64'd0,                   -64'sd5,               1'b1, 1'b0}, // R3 sge
    {8'hdd, 16'd5,      32'd0,         64'd0,                   -64'sd5,               1'b0, 1'b0}, // R3 sle
    {8'h15, 16'd6,      32'hffffffff,  64'hffffffffffffffff,    64'd0,                 1'b1, 1'b0}, // R4 sext imm
    {8'h15, 16'd6,      32'hffffffff,  64'h00000000ffffffff,    64'd0,                 1'b0, 1'b0}, // R4
    {8'h16, 16'd6,      32'hffffffff,  64'h00000000ffffffff,    64'd0,                 1'b1, 1'b0}, // R5 raw imm
    {8'h16, 16'd6,      32'hffffffff,  64'h12345678ffffffff,    64'd0,                 1'b1, 1'b0}, // R5 upper ignored
    {8'h66, 16'd1,      32'hffffffff,  64'h0,                   64'd0,                 1'b1, 1'b0}, // R5 signed 0 > -1
    {8'h26, 16'd1,      32'hffffffff,  64'h0,                   64'd0,                 1'b0, 1'b0}, // R5 unsigned
    {8'h1e, 16'd8,      32'd0,         64'haaaaaaaa00000007,    64'h5555555500000007,  1'b1, 1'b0}, // R5 reg eq
    {8'h1d, 16'd8,      32'd0,         64'haaaaaaaa00000007,    64'h5555555500000007,  1'b0, 1'b0}, // R5 wide differs
    {8'hce, 16'd2,      32'd0,         64'h0000000080000000,    64'd1,                 1'b1, 1'b0}, // R5 bit31 sign
    {8'hcd, 16'd2,      32'd0,         64'h0000000080000000,    64'd1,                 1'b0, 1'b0}, // R5 wide positive
    {8'h15, 16'd4,      32'd8,         64'd7,                   64'd7,                 1'b0, 1'b0}, // R2 imm chosen
    {8'h1d, 16'd4,      32'd8,         64'd7,                   64'd7,                 1'b1, 1'b0}, // R2 src chosen
    {8'h4d, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R8
    {8'hed, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R8
    {8'h06, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R8
    {8'h96, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R8
    {8'h1f, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R1 class 7
    {8'h1c, 16'd4,      32'd0,         64'd7,                   64'd7,                 1'b0, 1'b1}, // R1 class 4
    {8'h1d, 16'h7fff,   32'd0,         64'd1,                   64'd1,                 1'b1, 1'b0}, // R6 max fwd
    {8'h1d, 16'h8000,   32'd0,         64'd1,                   64'd1,                 1'b1, 1'b0}  // R6 max back
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [63:0]     insn = '0;
  logic [PC_W-1:0] pc = '0;
  logic [63:0]     dst_val = '0;
  logic [63:0]     src_val = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic            out_taken;
  logic [PC_W-1:0] out_next_pc;
  logic            out_illegal;
  int              checks = 0;
  int              errors = 0;
  int              cycles = 0;

  always #2 clk = !clk;

  pfb_branch_unit #(.PC_W(PC_W)) u_pfb_branch_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .pc(pc), .dst_val(dst_val), .src_val(src_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_next_pc(out_next_pc), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] model_next(input logic [PC_W-1:0] p,
                                                 input logic [15:0] o, input logic tk);
    longint sum;
    sum = longint'(p) + 1;
    if (tk) sum = sum + longint'($signed(o));
    return PC_W'(sum);
  endfunction

  task automatic issue(input logic [7:0] op, input logic [15:0] o, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s, input logic [PC_W-1:0] p);
    @(negedge clk);
    insn     = {op, 8'h21, o, im};
    pc       = p;
    dst_val  = d;
    src_val  = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 out_taken", 64'(out_taken), 64'd0);
    check("R10 out_illegal", 64'(out_illegal), 64'd0);
    check("R10 out_next_pc", 64'(out_next_pc), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 in_ready idle", 64'(in_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic [185:0] v;
      v = VEC[i];
      issue(v[185:178], v[177:162], v[161:130], v[129:66], v[65:2], 32'd1000);
      check($sformatf("R9 valid v%0d", i), 64'(out_valid), 64'd1);
      check($sformatf("R3 taken v%0d", i), 64'(out_taken), 64'(v[1]));
      check($sformatf("R8 illegal v%0d", i), 64'(out_illegal), 64'(v[0]));
      check($sformatf("R6 R7 next v%0d", i), 64'(out_next_pc),
            64'(model_next(32'd1000, v[177:162], v[1])));
    end

    // R6 / R7 wrap at the top of the PC range
    issue(8'h1d, 16'd0, 32'd0, 64'd3, 64'd3, 32'hffffffff);
    check("R6 wrap taken", 64'(out_next_pc), 64'd0);
    issue(8'h5d, 16'd9, 32'd0, 64'd3, 64'd3, 32'hffffffff);
    check("R7 wrap fallthrough", 64'(out_next_pc), 64'd0);
    issue(8'h1d, 16'h8000, 32'd0, 64'd3, 64'd3, 32'h00010000);
    check("R6 backward", 64'(out_next_pc), 64'h8001);

    // R9 stall: result held, new input blocked, then handed over
    @(negedge clk);
    out_ready = 1'b0;
    issue(8'h1d, 16'd5, 32'd0, 64'd1, 64'd1, 32'd50);
    insn = {8'h5d, 8'h21, 16'd5, 32'd0};
    pc = 32'd70;
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 stalled in_ready", 64'(in_ready), 64'd0);
    check("R9 stalled valid", 64'(out_valid), 64'd1);
    check("R9 stalled taken", 64'(out_taken), 64'd1);
    check("R9 stalled next", 64'(out_next_pc), 64'd56);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 handover valid", 64'(out_valid), 64'd1);
    check("R9 handover taken", 64'(out_taken), 64'd0);
    check("R9 handover next", 64'(out_next_pc), 64'd71);
    @(negedge clk);
    check("R9 drained", 64'(out_valid), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule